// File: doc/BRIEF.md
# Indirect Address Pointer Unit

This block holds the six byte registers that sit at the top of a processor's general-purpose register file and treats them, two at a time, as three 16-bit data-space address pointers named X, Y and Z. An access request names one pointer and one addressing mode. The block produces the effective address of that access. When the mode changes the pointer, the block also writes the new 16-bit value back into both bytes of the register pair in the same clock edge.

The same six bytes can also be written and read one at a time as ordinary registers through a direct port. A direct write and a pointer write-back can land on the same byte in one cycle. In that case the direct write takes that byte, and the other byte still receives its write-back value. The effective address and the direct read data come from output registers and appear one cycle after the request.

Top module: `idx_ptr_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all six bytes read as 0, `ea_valid` is 0 and `rd_data` is 0.
- R2: Direct byte index 0..5 maps to general registers 26..31. A write with `wr_en` updates that byte at the clock edge. `rd_data` shows the byte value from before that edge, one cycle after `rd_idx` is applied. Indices 6 and 7 ignore writes and read as 0.
- R3: Pointer select 0 = X = {byte1, byte0}, 1 = Y = {byte3, byte2}, 2 = Z = {byte5, byte4}. The lower-numbered register of each pair is the low byte.
- R4: Mode 0 (plain) gives `ea_addr` = pointer and leaves the pointer unchanged. `ea_valid` rises one cycle after an accepted request and is 0 one cycle after a cycle without a request.
- R5: Mode 1 (displacement) gives `ea_addr` = pointer + the zero-extended 6-bit `req_disp`, modulo 2^16, and leaves the pointer unchanged.
- R6: Mode 2 (post-increment) gives `ea_addr` = the old pointer and writes back pointer + 1.
- R7: Mode 3 (pre-decrement) writes back pointer - 1 and gives that new value as `ea_addr`.
- R8: Increment and decrement wrap modulo 2^16. The carry or borrow reaches the high byte in the same write-back (0x00FF+1 = 0x0100, 0x0000-1 = 0xFFFF, 0xFFFF+1 = 0x0000).
- R9: When a direct write and a write-back hit the same byte in one cycle, that byte takes the direct data. The partner byte takes its write-back value.
- R10: A request with select 3, or a displacement-mode request on X, is rejected. `ea_valid` is 0 on the next cycle and no byte changes.
- R11: Back-to-back requests on one pointer see the previous request's write-back without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Pointer access request |
| req_sel | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| req_mode | input | 2 | Addressing mode (0 plain, 1 displacement, 2 post-inc, 3 pre-dec) |
| req_disp | input | 6 | Unsigned displacement |
| wr_en | input | 1 | Direct byte write enable |
| wr_idx | input | 3 | Direct write byte index |
| wr_data | input | 8 | Direct write data |
| rd_idx | input | 3 | Direct read byte index |
| rd_data | output | 8 | Registered direct read data |
| ea_valid | output | 1 | Effective address valid |
| ea_addr | output | 16 | Registered effective address |

## Verification
The bench targets the pointer-wrap edges: 0xFFFF incremented, 0x0000 decremented, and 0x0100 decremented. A design that updates only the low byte would leave the high byte stale. The bench also covers a displacement that crosses the top of the address space. A design that saturates or drops the carry there would return a wrong address. A direct write that collides with a write-back is checked byte by byte, which catches both a design where the write-back wins and one where the partner byte is blocked. Rejected requests and chains of increments are compared on every clock against a behavioural model. That comparison catches a write-back that arrives a cycle late, a pre-decrement that returns the old address, and a displacement access on X that is wrongly allowed.

// File: rtl/idx_ptr_pkg.sv
package idx_ptr_pkg;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_DISP    = 2'd1,
    AM_POSTINC = 2'd2,
    AM_PREDEC  = 2'd3
  } addr_mode_e;

endpackage

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
  import idx_ptr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_PTR = 3,
  parameter int DISP_W  = 6,
  parameter int SEL_W   = 2,
  parameter logic [NUM_PTR-1:0] DISP_OK = 3'b110
) (
  input  logic                        req_valid,
  input  logic [SEL_W-1:0]            req_sel,
  input  logic [1:0]                  req_mode,
  input  logic [DISP_W-1:0]           req_disp,
  input  logic [NUM_PTR*2*DATA_W-1:0] ptr_flat,
  output logic                        acc,
  output logic [2*DATA_W-1:0]         ea_next,
  output logic [NUM_PTR-1:0]          wb_en,
  output logic [2*DATA_W-1:0]         wb_val
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  addr_mode_e      mode;
  logic            hit;
  logic            disp_ok;
  logic            wb_req;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] disp_ext;

  assign mode     = addr_mode_e'(req_mode);
  assign disp_ext = {{(ADDR_W-DISP_W){1'b0}}, req_disp};

  always_comb begin
    hit     = 1'b0;
    cur     = '0;
    disp_ok = 1'b0;
    for (int p = 0; p < NUM_PTR; p++) begin
      if (req_sel == SEL_W'(p)) begin
        hit     = 1'b1;
        cur     = ptr_flat[p*ADDR_W +: ADDR_W];
        disp_ok = DISP_OK[p];
      end
    end
  end

  assign acc = req_valid && hit && ((mode != AM_DISP) || disp_ok);

  always_comb begin
    ea_next = cur;
    wb_val  = cur;
    wb_req  = 1'b0;
    case (mode)
      AM_PLAIN:   ea_next = cur;
      AM_DISP:    ea_next = cur + disp_ext;
      AM_POSTINC: begin
        ea_next = cur;
        wb_val  = cur + ONE;
        wb_req  = 1'b1;
      end
      AM_PREDEC:  begin
        wb_val  = cur - ONE;
        ea_next = cur - ONE;
        wb_req  = 1'b1;
      end
      default:    ea_next = cur;
    endcase
  end

  always_comb begin
    for (int p = 0; p < NUM_PTR; p++) begin
      wb_en[p] = acc && wb_req && (req_sel == SEL_W'(p));
    end
  end

endmodule

// File: rtl/idx_reg_bank.sv
module idx_reg_bank #(
  parameter int DATA_W  = 8,
  parameter int NUM_PTR = 3,
  parameter int IDX_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [NUM_PTR-1:0]          wb_en,
  input  logic [2*DATA_W-1:0]         wb_val,
  output logic [NUM_PTR*2*DATA_W-1:0] q_flat
);

  localparam int NUM_REG = 2 * NUM_PTR;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_byte
    logic [DATA_W-1:0] q;
    logic              dir_hit;

    assign dir_hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (dir_hit) begin
        q <= wr_data;
      end else if (wb_en[g/2]) begin
        q <= wb_val[(g%2)*DATA_W +: DATA_W];
      end
    end

    assign q_flat[g*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/idx_rd_port.sv
module idx_rd_port #(
  parameter int DATA_W  = 8,
  parameter int NUM_REG = 6,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [IDX_W-1:0]          rd_idx,
  input  logic [NUM_REG*DATA_W-1:0] q_flat,
  output logic [DATA_W-1:0]         rd_data
);

  logic [DATA_W-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (rd_idx == IDX_W'(r)) sel_byte = q_flat[r*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel_byte;
  end

endmodule

// File: rtl/idx_ptr_unit.sv
module idx_ptr_unit #(
  parameter int DATA_W  = 8,
  parameter int NUM_PTR = 3,
  parameter int DISP_W  = 6,
  parameter logic [NUM_PTR-1:0] DISP_OK = 3'b110,
  localparam int ADDR_W  = 2 * DATA_W,
  localparam int NUM_REG = 2 * NUM_PTR,
  localparam int SEL_W   = $clog2(NUM_PTR + 1),
  localparam int IDX_W   = $clog2(NUM_REG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [1:0]        req_mode,
  input  logic [DISP_W-1:0] req_disp,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea_addr
);

  logic [NUM_REG*DATA_W-1:0] ptr_flat;
  logic                      acc;
  logic [ADDR_W-1:0]         ea_next;
  logic [NUM_PTR-1:0]        wb_en;
  logic [ADDR_W-1:0]         wb_val;

  idx_addr_calc #(
    .DATA_W(DATA_W), .NUM_PTR(NUM_PTR), .DISP_W(DISP_W),
    .SEL_W(SEL_W), .DISP_OK(DISP_OK)
  ) i_calc (
    .req_valid(req_valid), .req_sel(req_sel), .req_mode(req_mode),
    .req_disp(req_disp), .ptr_flat(ptr_flat), .acc(acc),
    .ea_next(ea_next), .wb_en(wb_en), .wb_val(wb_val)
  );

  idx_reg_bank #(
    .DATA_W(DATA_W), .NUM_PTR(NUM_PTR), .IDX_W(IDX_W)
  ) i_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .wb_en(wb_en), .wb_val(wb_val), .q_flat(ptr_flat)
  );

  idx_rd_port #(
    .DATA_W(DATA_W), .NUM_REG(NUM_REG), .IDX_W(IDX_W)
  ) i_rd (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .q_flat(ptr_flat), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid <= 1'b0;
      ea_addr  <= '0;
    end else begin
      ea_valid <= acc;
      if (acc) ea_addr <= ea_next;
    end
  end

endmodule

// File: rtl/idx_ptr_unit_chk.sv
module idx_ptr_unit_chk #(
  parameter int DATA_W  = 8,
  parameter int NUM_PTR = 3,
  parameter int SEL_W   = 2,
  parameter int IDX_W   = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_valid,
  input logic [SEL_W-1:0]            req_sel,
  input logic [1:0]                  req_mode,
  input logic                        wr_en,
  input logic [IDX_W-1:0]            wr_idx,
  input logic [DATA_W-1:0]           wr_data,
  input logic [DATA_W-1:0]           rd_data,
  input logic                        ea_valid,
  input logic [2*DATA_W-1:0]         ea_addr,
  input logic [NUM_PTR*2*DATA_W-1:0] ptr_flat
);

  localparam int AW = 2 * DATA_W;

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!ea_valid && ptr_flat == '0 && rd_data == '0));

  p_idle_no_valid_r4: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !ea_valid);

  p_disp_keeps_ptr_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd1 && !wr_en) |=> $stable(ptr_flat));

  p_postinc_x_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sel == '0 && req_mode == 2'd2 && !wr_en) |=>
      (ptr_flat[AW-1:0] == $past(ptr_flat[AW-1:0]) + AW'(1)) &&
      (ea_addr == $past(ptr_flat[AW-1:0])) && ea_valid);

  p_predec_z_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sel == SEL_W'(2) && req_mode == 2'd3 && !wr_en) |=>
      (ptr_flat[2*AW +: AW] == $past(ptr_flat[2*AW +: AW]) - AW'(1)) &&
      (ea_addr == ptr_flat[2*AW +: AW]) && ea_valid);

  p_direct_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(1)) |=> ptr_flat[DATA_W +: DATA_W] == $past(wr_data));

  p_reject_sel3_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sel == SEL_W'(3)) |=> !ea_valid);

  p_reject_disp_x_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sel == '0 && req_mode == 2'd1) |=> !ea_valid);

endmodule

bind idx_ptr_unit idx_ptr_unit_chk #(
  .DATA_W(DATA_W), .NUM_PTR(NUM_PTR), .SEL_W(SEL_W), .IDX_W(IDX_W)
) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
  .req_mode(req_mode), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_data(rd_data), .ea_valid(ea_valid), .ea_addr(ea_addr), .ptr_flat(ptr_flat)
);

// File: tb/test_idx_ptr_unit.sv
`timescale 1ns/1ps
module test_idx_ptr_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_sel = '0;
  logic [1:0] req_mode = '0;
  logic [5:0] req_disp = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       ea_valid;
  logic [15:0] ea_addr;

  int checks = 0;
  int failures = 0;
  int bank [6];
  bit exp_v;
  int exp_ea;
  int exp_rd;

  always #4 clk = ~clk;

  idx_ptr_unit i_idx_ptr_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
    .req_mode(req_mode), .req_disp(req_disp), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .ea_valid(ea_valid), .ea_addr(ea_addr)
  );

  task automatic check(string tag, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  // One cycle: drive at negedge, model, then compare at the next negedge.
  task automatic step(string tag, bit rv, int sel, int mode, int disp,
                      bit we, int widx, int wdata, int ridx);
    int p;
    int np;
    bit legal;
    req_valid = rv; req_sel = sel[1:0]; req_mode = mode[1:0];
    req_disp = disp[5:0]; wr_en = we; wr_idx = widx[2:0];
    wr_data = wdata[7:0]; rd_idx = ridx[2:0];
    legal = rv && sel < 3 && !(sel == 0 && mode == 1);
    exp_rd = (ridx < 6) ? bank[ridx] : 0;
    exp_v = legal;
    if (legal) begin
      p = bank[2*sel+1] * 256 + bank[2*sel];
      np = p;
      case (mode)
        0: exp_ea = p;
        1: exp_ea = (p + disp) % 65536;
        2: begin exp_ea = p; np = (p + 1) % 65536; end
        default: begin np = (p + 65535) % 65536; exp_ea = np; end
      endcase
      bank[2*sel]   = np % 256;
      bank[2*sel+1] = np / 256;
    end
    if (we && widx < 6) bank[widx] = wdata;
    @(negedge clk);
    check(tag, int'(ea_valid), int'(exp_v), "ea_valid");
    if (exp_v) check(tag, int'(ea_addr), exp_ea, "ea_addr");
    check(tag, int'(rd_data), exp_rd, "rd_data");
  endtask

  task automatic idle(string tag, int ridx);
    step(tag, 0, 0, 0, 0, 0, 0, 0, ridx);
  endtask

  task automatic set_ptr(int sel, int val);
    step("R2", 0, 0, 0, 0, 1, 2*sel, val % 256, 0);
    step("R2", 0, 0, 0, 0, 1, 2*sel+1, val / 256, 0);
  endtask

  task automatic read_byte(string tag, int idx, int expv);
    idle(tag, idx);
    idle(tag, idx);
    check(tag, int'(rd_data), expv, "byte readback");
  endtask

  initial begin
    #200000000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) bank[i] = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(ea_valid), 0, "reset ea_valid");
    check("R1", int'(rd_data), 0, "reset rd_data");
    rst = 1'b0;
    for (int i = 0; i < 8; i++) idle("R1", i);

    // R2: direct write of each byte, read back, out-of-range index
    for (int i = 0; i < 6; i++) step("R2", 0, 0, 0, 0, 1, i, 8'h10 + i * 17, 0);
    for (int i = 0; i < 6; i++) read_byte("R2", i, 8'h10 + i * 17);
    step("R2", 0, 0, 0, 0, 1, 6, 8'hAA, 6);
    read_byte("R2", 6, 0);
    read_byte("R2", 7, 0);

    // R3 / R4: plain access of each pointer, pairing of bytes
    set_ptr(0, 16'h1234); set_ptr(1, 16'hBEEF); set_ptr(2, 16'h0F0E);
    step("R3", 1, 0, 0, 0, 0, 0, 0, 1);
    step("R3", 1, 1, 0, 0, 0, 0, 0, 3);
    step("R4", 1, 2, 0, 0, 0, 0, 0, 4);
    check("R4", int'(ea_addr), 16'h0F0E, "plain Z address");
    idle("R4", 0);
    check("R4", int'(ea_valid), 0, "valid drops without request");

    // R5: displacement, including wrap past the top
    step("R5", 1, 1, 1, 63, 0, 0, 0, 2);
    check("R5", int'(ea_addr), 16'hBEEF + 63, "Y plus 63");
    set_ptr(2, 16'hFFF0);
    step("R5", 1, 2, 1, 63, 0, 0, 0, 4);
    check("R5", int'(ea_addr), 16'h002F, "Z displacement wrap");
    read_byte("R5", 5, 8'hFF);

    // R6 / R8: post-increment at 0x00FF and 0xFFFF
    set_ptr(0, 16'h00FF);
    step("R6", 1, 0, 2, 0, 0, 0, 0, 0);
    check("R6", int'(ea_addr), 16'h00FF, "post-inc gives old");
    read_byte("R8", 1, 8'h01);
    set_ptr(0, 16'hFFFF);
    step("R8", 1, 0, 2, 0, 0, 0, 0, 0);
    read_byte("R8", 0, 0);
    read_byte("R8", 1, 0);

    // R7 / R8: pre-decrement with borrow and underflow
    set_ptr(2, 16'h0100);
    step("R7", 1, 2, 3, 0, 0, 0, 0, 4);
    check("R7", int'(ea_addr), 16'h00FF, "pre-dec gives new");
    read_byte("R8", 5, 0);
    set_ptr(1, 16'h0000);
    step("R8", 1, 1, 3, 0, 0, 0, 0, 2);
    check("R8", int'(ea_addr), 16'hFFFF, "pre-dec underflow");

    // R9: direct write collides with write-back on high byte of Y
    set_ptr(1, 16'h12FF);
    step("R9", 1, 1, 2, 0, 1, 3, 8'h77, 0);
    read_byte("R9", 3, 8'h77);
    read_byte("R9", 2, 8'h00);

    // R10: rejected requests change nothing
    set_ptr(0, 16'h4321);
    step("R10", 1, 3, 2, 0, 0, 0, 0, 0);
    check("R10", int'(ea_valid), 0, "select 3 rejected");
    step("R10", 1, 0, 1, 5, 0, 0, 0, 0);
    check("R10", int'(ea_valid), 0, "displacement on X rejected");
    read_byte("R10", 0, 8'h21);
    read_byte("R10", 1, 8'h43);

    // R11: back-to-back post-increments
    for (int i = 0; i < 4; i++) step("R11", 1, 0, 2, 0, 0, 0, 0, 0);
    check("R11", int'(ea_addr), 16'h4324, "fourth address in chain");

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int m;
      m = $urandom_range(0, 3);
      step(m == 0 ? "R4" : m == 1 ? "R5" : m == 2 ? "R6" : "R7",
           $urandom_range(0, 3) != 0, $urandom_range(0, 3), m,
           $urandom_range(0, 63), $urandom_range(0, 3) == 0,
           $urandom_range(0, 7), $urandom_range(0, 255), $urandom_range(0, 7));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule